// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is a serial slave port. It gives an external host read and write access to a small array of byte-wide registers. A frame starts when the host drives the active-low select low. The first sixteen bits form an instruction, which carries a read/write flag, a length code and a start address. One, two or three data bytes follow, or an open-ended stream of bytes that runs until the select is released. On reads the block launches data on the falling serial clock edge, so the host can sample it on its next rising edge. The data leaves either on the shared bidirectional pin or on a separate output pin.

Register 0 sets how the port behaves. One bit selects LSB-first transfer, for both the instruction and the data. Another bit moves read data onto the separate output pin. A change to register 0 takes effect from the next frame. On-chip logic reaches the same array through a simple parallel port. All serial inputs are oversampled by the system clock, so the whole block lives in one clock domain.

Top module: `spiRegSlave`

## Requirements
- R1: A frame starts on the first rising serial clock edge while the select is low. The first 16 bits received form the instruction: bit 15 is read (1) or write (0), bits 14:13 are the length code, and bits 12:0 are the start address.
- R2: Length codes 00, 01 and 10 transfer exactly 1, 2 and 3 data bytes. Serial clocks after the last byte of such a frame change no register.
- R3: Length code 11 streams data bytes, with no byte limit, until the select goes high. That ends the frame.
- R4: If the select goes high at any point other than a data byte boundary, the frame is abandoned. Bytes already completed stay written, the partial byte is dropped, and the next frame decodes a fresh instruction.
- R5: In a 1, 2 or 3-byte frame the select may go high at a data byte boundary and low again later. The transfer then resumes with the next byte at the next address.
- R6: Read data is launched on the falling serial clock edge and holds until the host's next rising edge. An output enable is active only while the select is low in the data phase of a read frame.
- R7: Register 0 bit 1 set routes read data to sdoOut with sdoOe high and sdioOe low. With the bit clear, the data goes to sdioOut with sdioOe high and sdoOe low. The two enables are never high together.
- R8: Register 0 bit 0 set selects LSB-first order, in which bit 0 of the instruction and of each data byte is sent first. With the bit clear, the order is MSB-first. A new value of register 0 applies from the next frame.
- R9: After each data byte the address decrements in MSB-first mode and increments in LSB-first mode, wrapping in 13 bits. The register accessed is the address modulo DEPTH.
- R10: A written byte is stored when its eighth bit arrives. A read byte is fetched before its first bit is launched.
- R11: The parallel port reads combinationally and writes on parWe. A serial write in the same cycle takes priority.
- R12: Reset clears every register to zero, which gives MSB-first order with the separate output disabled. Reset also turns both output enables off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial inputs |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low frame select |
| sdioIn | input | 1 | Input side of the shared data pin |
| sdioOut | output | 1 | Output side of the shared data pin |
| sdioOe | output | 1 | Drive enable of the shared data pin |
| sdoOut | output | 1 | Separate read-data output |
| sdoOe | output | 1 | Drive enable of the separate output |
| parAddr | input | $clog2(DEPTH) | Parallel port register index |
| parWe | input | 1 | Parallel port write strobe |
| parWdata | input | 8 | Parallel port write data |
| parRdata | output | 8 | Parallel port read data |

## Verification
The hardest situation to reach from the pins is a frame interrupted at a precise point. Telling a boundary stall (which must resume) apart from a mid-byte release (which must abort) requires the select to rise on an exact bit count. The bench's frame task therefore takes a stall flag and an abort byte index. It raises the select either after a whole byte or after four bits of a chosen byte, and then reads the array back through the parallel port. A switch of register 0 partway through a sequence is reached by writing it in one frame. The bench then confirms that bit order and output pin change only in the following frame.

// File: rtl/spiRegPkg.sv
package spiRegPkg;
  localparam int INSTR_W = 16;
  localparam int ADDR_W  = 13;

  // strobes from the control to the datapath, one cycle wide
  typedef struct packed {
    logic shiftRx;   // take the sampled input bit
    logic decode;    // instruction complete this cycle
    logic commit;    // store received byte
    logic fetch;     // load transmit byte
    logic advance;   // step the address
    logic shiftTx;   // launch next read bit
    logic latchCfg;  // copy register 0 into frame settings
  } strobeT;
endpackage

// File: rtl/spiRegCtrl.sv
module spiRegCtrl
  import spiRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       sdioIn,
  input  logic       instrRead,
  input  logic [1:0] instrLen,
  output strobeT     stb,
  output logic       sdiBit,
  output logic       readActive
);
  typedef enum logic [1:0] {ST_INSTR, ST_DATA, ST_DONE} stateT;

  logic [2:0] sclkQ;
  logic [1:0] csQ;
  logic [1:0] sdiQ;
  stateT      state;
  logic [3:0] bitCnt;
  logic [1:0] byteCnt;
  logic [1:0] lenCode;
  logic       isRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= '0;
      csQ   <= '0;
      sdiQ  <= '0;
    end else begin
      sclkQ <= {sclkQ[1:0], sclk};
      csQ   <= {csQ[0], ~csN};
      sdiQ  <= {sdiQ[0], sdioIn};
    end
  end

  logic sclkRise, sclkFall, csActive, atBoundary;
  assign sclkRise   = sclkQ[1] & ~sclkQ[2];
  assign sclkFall   = ~sclkQ[1] & sclkQ[2];
  assign csActive   = csQ[1];
  assign sdiBit     = sdiQ[1];
  assign atBoundary = (state == ST_DATA) && (bitCnt == 4'd0) && (lenCode != 2'b11);
  assign readActive = csActive && (state != ST_INSTR) && isRead;

  always_comb begin
    stb = '0;
    stb.latchCfg = (state == ST_INSTR) && (bitCnt == 4'd0) && !csActive;
    if (csActive && sclkRise) begin
      if (state == ST_INSTR) begin
        stb.shiftRx = 1'b1;
        if (bitCnt == 4'd15) begin
          stb.decode = 1'b1;
          stb.fetch  = instrRead;
        end
      end else if (state == ST_DATA) begin
        stb.shiftRx = !isRead;
        if (bitCnt == 4'd7) begin
          stb.advance = 1'b1;
          stb.commit  = !isRead;
          stb.fetch   = isRead;
        end
      end
    end
    if (csActive && sclkFall && (state == ST_DATA) && isRead) stb.shiftTx = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_INSTR;
      bitCnt  <= '0;
      byteCnt <= '0;
      lenCode <= '0;
      isRead  <= 1'b0;
    end else if (!csActive) begin
      if (!atBoundary) begin
        state   <= ST_INSTR;
        bitCnt  <= '0;
        byteCnt <= '0;
        isRead  <= 1'b0;
      end
    end else if (sclkRise) begin
      case (state)
        ST_INSTR: begin
          if (bitCnt == 4'd15) begin
            state   <= ST_DATA;
            bitCnt  <= '0;
            byteCnt <= '0;
            isRead  <= instrRead;
            lenCode <= instrLen;
          end else begin
            bitCnt <= bitCnt + 4'd1;
          end
        end
        ST_DATA: begin
          if (bitCnt == 4'd7) begin
            bitCnt <= '0;
            if (lenCode != 2'b11) begin
              if (byteCnt == lenCode) state <= ST_DONE;
              else byteCnt <= byteCnt + 2'd1;
            end
          end else begin
            bitCnt <= bitCnt + 4'd1;
          end
        end
        default: ;
      endcase
    end
  end

  // R4: release mid-byte drops back to instruction decode
  a_r4_abort_resets: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive && state == ST_DATA && bitCnt != 4'd0) |=> (state == ST_INSTR && bitCnt == 4'd0));

  // R5: release on a boundary of a fixed-length frame keeps position
  a_r5_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive && atBoundary) |=> (state == ST_DATA && $stable(byteCnt)));

  // R2: byte counter never passes the requested length
  a_r2_bytecnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_INSTR && lenCode != 2'b11) |-> (byteCnt <= lenCode));

  // R3: a stream ends when the select is released
  a_r3_stream_ends: assert property (@(posedge clk) disable iff (!rstN)
    (!csActive && state == ST_DATA && lenCode == 2'b11) |=> (state == ST_INSTR));
endmodule

// File: rtl/spiRegDatapath.sv
module spiRegDatapath
  import spiRegPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic             sdiBit,
  input  logic [IDX_W-1:0] parAddr,
  input  logic             parWe,
  input  logic [7:0]       parWdata,
  output logic [7:0]       parRdata,
  output logic             instrRead,
  output logic [1:0]       instrLen,
  output logic             txBit,
  output logic             sdoEn
);
  logic [7:0]         regs [DEPTH];
  logic [INSTR_W-1:0] rxShift, rxNext;
  logic [ADDR_W-1:0]  addr, addrStep, fetchAddr;
  logic [7:0]         rxByte, txShift;
  logic               lsbFirst;

  assign rxNext    = lsbFirst ? {sdiBit, rxShift[INSTR_W-1:1]} : {rxShift[INSTR_W-2:0], sdiBit};
  assign rxByte    = lsbFirst ? rxNext[INSTR_W-1:INSTR_W-8] : rxNext[7:0];
  assign instrRead = rxNext[INSTR_W-1];
  assign instrLen  = rxNext[INSTR_W-2:INSTR_W-3];
  assign addrStep  = lsbFirst ? addr + 1'b1 : addr - 1'b1;
  assign fetchAddr = stb.decode ? rxNext[ADDR_W-1:0] : addrStep;
  assign parRdata  = regs[parAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (stb.commit) begin
      regs[addr[IDX_W-1:0]] <= rxByte;
    end else if (parWe) begin
      regs[parAddr] <= parWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      addr     <= '0;
      txShift  <= '0;
      txBit    <= 1'b0;
      lsbFirst <= 1'b0;
      sdoEn    <= 1'b0;
    end else begin
      if (stb.shiftRx) rxShift <= rxNext;
      if (stb.decode) addr <= rxNext[ADDR_W-1:0];
      else if (stb.advance) addr <= addrStep;
      if (stb.fetch) txShift <= regs[fetchAddr[IDX_W-1:0]];
      else if (stb.shiftTx) begin
        txBit   <= lsbFirst ? txShift[0] : txShift[7];
        txShift <= lsbFirst ? {1'b0, txShift[7:1]} : {txShift[6:0], 1'b0};
      end
      if (stb.latchCfg) {sdoEn, lsbFirst} <= regs[0][1:0];
    end
  end

  // R9: address steps by one per byte in the direction set by the bit order
  a_r9_addr_down: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.decode && !lsbFirst) |=> (addr == $past(addr) - 13'd1));
  a_r9_addr_up: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.decode && lsbFirst) |=> (addr == $past(addr) + 13'd1));

  // R10: a committed byte lands in the addressed register
  a_r10_commit_value: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> (regs[$past(addr[IDX_W-1:0])] == $past(rxByte)));
endmodule

// File: rtl/spiRegSlave.sv
module spiRegSlave
  import spiRegPkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csN,
  input  logic             sdioIn,
  output logic             sdioOut,
  output logic             sdioOe,
  output logic             sdoOut,
  output logic             sdoOe,
  input  logic [IDX_W-1:0] parAddr,
  input  logic             parWe,
  input  logic [7:0]       parWdata,
  output logic [7:0]       parRdata
);
  strobeT     stb;
  logic       sdiBit, readActive, instrRead, txBit, sdoEn;
  logic [1:0] instrLen;

  spiRegCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .instrRead(instrRead), .instrLen(instrLen),
    .stb(stb), .sdiBit(sdiBit), .readActive(readActive)
  );

  spiRegDatapath #(.DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiBit(sdiBit),
    .parAddr(parAddr), .parWe(parWe), .parWdata(parWdata), .parRdata(parRdata),
    .instrRead(instrRead), .instrLen(instrLen), .txBit(txBit), .sdoEn(sdoEn)
  );

  assign sdioOut = txBit;
  assign sdoOut  = txBit;
  assign sdioOe  = readActive & ~sdoEn;
  assign sdoOe   = readActive & sdoEn;

  // R7: never two drivers of read data
  a_r7_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sdioOe, sdoOe}));
endmodule

// File: tb/test_spiRegSlave.sv
module test_spiRegSlave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 8;
  localparam int DEPTH = 32;

  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, sdioIn = 1'b0;
  logic sdioOut, sdioOe, sdoOut, sdoOe;
  logic [4:0] parAddr = '0;
  logic parWe = 1'b0;
  logic [7:0] parWdata = '0;
  logic [7:0] parRdata;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [7:0] mem [DEPTH];
  logic [7:0] txData [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  spiRegSlave #(.DEPTH(DEPTH)) i_spiRegSlave (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdioIn(sdioIn),
    .sdioOut(sdioOut), .sdioOe(sdioOe), .sdoOut(sdoOut), .sdoOe(sdoOe),
    .parAddr(parAddr), .parWe(parWe), .parWdata(parWdata), .parRdata(parRdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xferBit(input logic b, output logic rb);
    @(negedge clk) sdioIn = b;
    repeat (HALF) @(negedge clk);
    rb = sdoOe ? sdoOut : sdioOut;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] v, input bit lsb, input int nb, output logic [7:0] r);
    r = '0;
    for (int i = 0; i < nb; i++) begin
      logic rb;
      int p;
      p = lsb ? i : 7 - i;
      xferBit(v[p], rb);
      r[p] = rb;
    end
  endtask

  function automatic logic [12:0] stepAddr(input logic [12:0] a, input bit lsb);
    return lsb ? a + 13'd1 : a - 13'd1;
  endfunction

  task automatic runFrame(input bit rd, input logic [1:0] len, input logic [12:0] a,
                          input int n, input bit stall, input int abortByte);
    bit lsb, sdoE;
    logic [15:0] ins;
    logic [12:0] ca;
    logic [7:0] r;
    int lim;
    lsb  = mem[0][0];
    sdoE = mem[0][1];
    ins  = {rd, len, a};
    lim  = (len == 2'b11) ? n : ((n < int'(len) + 1) ? n : int'(len) + 1);
    ca   = a;
    csN  = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      logic rb;
      int p;
      p = lsb ? i : 15 - i;
      xferBit(ins[p], rb);
    end
    for (int j = 0; j < n; j++) begin
      if (stall && j > 0) begin
        repeat (HALF) @(negedge clk);
        csN = 1'b1;
        repeat (3*HALF) @(negedge clk);
        csN = 1'b0;
        repeat (HALF) @(negedge clk);
      end
      if (j == abortByte) begin
        sendByte(txData[j], lsb, 4, r);
        break;
      end
      sendByte(txData[j], lsb, 8, r);
      if (rd && j == 0)
        check(sdoOe == sdoE && sdioOe == !sdoE, "R7 pin select", {sdoOe, sdioOe}, {sdoE, !sdoE});
      if (j < lim) begin
        if (rd) check(r == mem[ca[4:0]], lsb ? "R8 R9 R6 read" : "R6 R9 R10 read", r, mem[ca[4:0]]);
        else mem[ca[4:0]] = txData[j];
        ca = stepAddr(ca, lsb);
      end
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2*HALF) @(negedge clk);
    check(!sdioOe && !sdoOe, "R6 enables off after frame", {sdoOe, sdioOe}, 0);
  endtask

  task automatic verifyAll(input string req);
    for (int k = 0; k < DEPTH; k++) begin
      parAddr = 5'(k);
      @(negedge clk);
      check(parRdata == mem[k], req, parRdata, mem[k]);
    end
  endtask

  task automatic wr1(input logic [12:0] a, input logic [7:0] v);
    txData[0] = v;
    runFrame(1'b0, 2'b00, a, 1, 1'b0, -1);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < DEPTH; k++) mem[k] = '0;
    repeat (4) @(negedge clk);
    check(!sdioOe && !sdoOe, "R12 enables in reset", {sdoOe, sdioOe}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    verifyAll("R12 reset contents");

    // R1 R10: single byte write
    wr1(13'd5, 8'hA5);
    // R5: three bytes with stalls at boundaries, MSB-first address descends
    txData[0] = 8'h11; txData[1] = 8'h22; txData[2] = 8'h33;
    runFrame(1'b0, 2'b10, 13'd20, 3, 1'b1, -1);
    runFrame(1'b1, 2'b10, 13'd20, 3, 1'b1, -1);
    // R2: extra byte after a one-byte frame is ignored
    txData[0] = 8'h7E; txData[1] = 8'hC3;
    runFrame(1'b0, 2'b00, 13'd7, 2, 1'b0, -1);
    verifyAll("R2 length limit");
    // R4: abort in the middle of the second byte
    txData[0] = 8'h5A; txData[1] = 8'hFF; txData[2] = 8'hEE;
    runFrame(1'b0, 2'b10, 13'd12, 3, 1'b0, 1);
    verifyAll("R4 abort keeps completed bytes only");
    wr1(13'd14, 8'h3C);
    verifyAll("R4 next frame decodes fresh");
    // R3: streaming write and read
    for (int j = 0; j < 5; j++) txData[j] = 8'(8'h90 + j);
    runFrame(1'b0, 2'b11, 13'd30, 5, 1'b0, -1);
    runFrame(1'b1, 2'b11, 13'd30, 5, 1'b0, -1);
    verifyAll("R3 stream write");
    // R11: parallel write then serial read
    @(negedge clk); parAddr = 5'd9; parWdata = 8'h5C; parWe = 1'b1;
    @(negedge clk); parWe = 1'b0; mem[9] = 8'h5C;
    check(parRdata == 8'h5C, "R11 parallel readback", parRdata, 8'h5C);
    runFrame(1'b1, 2'b00, 13'd9, 1, 1'b0, -1);
    // R8: switch to LSB-first, applies from next frame; address ascends (R9)
    wr1(13'd0, 8'h01);
    for (int j = 0; j < 3; j++) txData[j] = 8'(8'h1D + 8'h21*j);
    runFrame(1'b0, 2'b10, 13'd3, 3, 1'b0, -1);
    runFrame(1'b1, 2'b11, 13'd3, 3, 1'b0, -1);
    // R7: enable separate output (written in LSB mode)
    wr1(13'd0, 8'h03);
    runFrame(1'b1, 2'b01, 13'd4, 2, 1'b1, -1);
    wr1(13'd0, 8'h02);
    runFrame(1'b1, 2'b10, 13'd22, 3, 1'b0, -1);
    wr1(13'd0, 8'h00);
    // R9: 13-bit address with high bits set maps by modulo
    txData[0] = 8'h6B;
    runFrame(1'b0, 2'b00, 13'h1FF1, 1, 1'b0, -1);
    verifyAll("R9 R8 after mode changes");

    // random frames
    for (int t = 0; t < 40; t++) begin
      bit rd, st;
      logic [1:0] len;
      logic [12:0] a;
      int n;
      rd  = 1'($urandom % 2);
      len = 2'($urandom % 4);
      a   = {8'($urandom), 5'(6 + $urandom % 20)};
      n   = (len == 2'b11) ? 1 + int'($urandom % 5) : int'(len) + 1 + int'($urandom % 2);
      st  = (len != 2'b11) && ($urandom % 3 == 0);
      for (int j = 0; j < 8; j++) txData[j] = 8'($urandom);
      runFrame(rd, len, a, n, st, -1);
    end
    verifyAll("R1 R2 R3 random frames");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule